// File: doc/BRIEF.md
# Selectable Sync Clock Divider

This block produces the clock that paces the switching regulators. It has three sources. By default it passes on a free-running internal oscillator. It can instead divide an external synchronisation clock by 3 or by 6. The division counts both rising and falling transitions of the external clock, so the divided output keeps a 50 % duty cycle even for the odd ratio.

The source is chosen by a configuration byte written with a strobe. Two one-hot select bits pick the ratio. The state with both bits set is invalid: it raises an error flag and falls back to the internal oscillator. A third bit records whether the external clock arrives on the AC-coupled or the DC-coupled path. Here that bit is only held and reported as a flag. While any regulator is running, writes to the configuration are thrown away and the last accepted setting stays in force.

Both clock inputs are level signals sampled by the system clock `clk` through a synchroniser. All outputs are registers.

Top module: `syncclk_divider`

## Requirements
- R1: A synchronous active-high reset clears `sync_clk_out`, `cfg_err` and `ac_coupled` to 0 and selects the internal oscillator.
- R2: With cfg bits 6 and 5 both 0, `sync_clk_out` after clock edge n equals the `int_osc` level sampled at edge n-2 (two synchroniser stages plus the output register).
- R3: With bit 6 = 1 and bit 5 = 0, `sync_clk_out` toggles once for every 3 synchronised transitions of `ext_sync`, either polarity. This gives one output period per three input periods at 50 % duty.
- R4: With bit 5 = 1 and bit 6 = 0, `sync_clk_out` toggles once for every 6 synchronised transitions of `ext_sync`.
- R5: With bits 6 and 5 both 1, `cfg_err` is 1 from the cycle after the write, and the output follows the internal oscillator as in R2.
- R6: `ac_coupled` takes the value of cfg bit 4 from the cycle after an accepted write.
- R7: A write strobed while `running` is 1 is discarded. The selected source, divider phase, `cfg_err` and `ac_coupled` are kept.
- R8: An accepted write restarts the divider: its count returns to zero and its phase to low.
- R9: Cfg bits 7 and 3 to 0 have no effect on any output.
- R10: A later accepted write with a valid select pair clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sync | input | 1 | External synchronisation clock level |
| int_osc | input | 1 | Internal oscillator level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration byte (bit 6 divide-by-3, bit 5 divide-by-6, bit 4 AC path) |
| running | input | 1 | High while any regulator is switching |
| sync_clk_out | output | 1 | Selected regulator clock |
| cfg_err | output | 1 | Invalid select pair latched |
| ac_coupled | output | 1 | AC input path selected |

## Verification
The assertions assume that `ext_sync` and `int_osc` are ordinary level inputs sampled once per `clk` cycle. They also assume that `cfg_wr`, `cfg_data` and `running` are synchronous to `clk` and hold steady around each edge. The bench changes every input only on the falling edge of `clk`. It holds each `ext_sync` level for one to three cycles, so every transition is seen by the synchroniser. It raises `running` across some writes, so the lock path is exercised from both sides.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Field positions inside the configuration byte.
  localparam int unsigned CFG_W      = 8;
  localparam int unsigned SEL_LO_BIT = 6;  // divide-by-3 select
  localparam int unsigned SEL_HI_BIT = 5;  // divide-by-6 select
  localparam int unsigned COUPLE_BIT = 4;  // AC path flag

  typedef enum logic [1:0] {
    SRC_INT    = 2'd0,
    SRC_DIV_LO = 2'd1,
    SRC_DIV_HI = 2'd2,
    SRC_BAD    = 2'd3
  } src_e;

  function automatic src_e decode_src(input logic sel_lo, input logic sel_hi);
    case ({sel_lo, sel_hi})
      2'b10:   decode_src = SRC_DIV_LO;
      2'b01:   decode_src = SRC_DIV_HI;
      2'b11:   decode_src = SRC_BAD;
      default: decode_src = SRC_INT;
    endcase
  endfunction

  function automatic logic src_is_div(input src_e s);
    src_is_div = (s == SRC_DIV_LO) || (s == SRC_DIV_HI);
  endfunction

endpackage

// File: rtl/sdiv_sync.sv
module sdiv_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sdiv_cfg.sv
module sdiv_cfg
  import sdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] data,
  input  logic             running,
  output src_e             src_q,
  output logic             ac_q,
  output logic             err_q,
  output logic             restart
);

  src_e src_d;

  // A write counts only while no regulator is switching.
  assign restart = wr && !running;
  assign src_d   = decode_src(data[SEL_LO_BIT], data[SEL_HI_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_INT;
      ac_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (restart) begin
      src_q <= src_d;
      ac_q  <= data[COUPLE_BIT];
      err_q <= (src_d == SRC_BAD);
    end
  end

endmodule

// File: rtl/sdiv_edge_div.sv
module sdiv_edge_div
  import sdiv_pkg::*;
#(
  parameter int unsigned RATIO_LO = 3,
  parameter int unsigned RATIO_HI = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic restart,
  input  src_e src,
  output logic div_q
);

  localparam int unsigned MAX_RATIO = (RATIO_LO > RATIO_HI) ? RATIO_LO : RATIO_HI;
  localparam int unsigned CNT_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(RATIO_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(RATIO_HI - 1);

  logic             lvl_prev;
  logic             edge_seen;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign edge_seen = lvl ^ lvl_prev;
  assign last      = (src == SRC_DIV_HI) ? LAST_HI : LAST_LO;

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b0;
    else     lvl_prev <= lvl;
  end

  // Count transitions of either polarity; toggle after RATIO of them.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (src_is_div(src) && edge_seen) begin
      if (cnt == last) begin
        cnt   <= '0;
        div_q <= !div_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/syncclk_divider.sv
module syncclk_divider
  import sdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RATIO_LO    = 3,
  parameter int unsigned RATIO_HI    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sync,
  input  logic             int_osc,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             running,
  output logic             sync_clk_out,
  output logic             cfg_err,
  output logic             ac_coupled
);

  localparam int unsigned N_IN = 2;
  localparam int unsigned IX_EXT = 0;
  localparam int unsigned IX_INT = 1;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] synced;
  src_e            src;
  logic            restart;
  logic            div_q;
  logic            out_d;

  assign raw_in[IX_EXT] = ext_sync;
  assign raw_in[IX_INT] = int_osc;

  sdiv_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_IN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (synced)
  );

  sdiv_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .data    (cfg_data),
    .running (running),
    .src_q   (src),
    .ac_q    (ac_coupled),
    .err_q   (cfg_err),
    .restart (restart)
  );

  sdiv_edge_div #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_div (
    .clk     (clk),
    .rst     (rst),
    .lvl     (synced[IX_EXT]),
    .restart (restart),
    .src     (src),
    .div_q   (div_q)
  );

  // The invalid pair and the idle pair both fall back to the internal oscillator.
  assign out_d = src_is_div(src) ? div_q : synced[IX_INT];

  always_ff @(posedge clk) begin
    if (rst) sync_clk_out <= 1'b0;
    else     sync_clk_out <= out_d;
  end

endmodule

// File: rtl/syncclk_divider_chk.sv
module syncclk_divider_chk (
  input logic       clk,
  input logic       rst,
  input logic       int_osc,
  input logic       cfg_wr,
  input logic [7:0] cfg_data,
  input logic       running,
  input logic       sync_clk_out,
  input logic       cfg_err,
  input logic       ac_coupled
);

  // R1: reset clears every output
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sync_clk_out && !cfg_err && !ac_coupled));

  // R7: a locked write leaves the flags untouched
  a_r7_locked_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && running) |=> ($stable(cfg_err) && $stable(ac_coupled)));

  // R5: both select bits set raises the error flag
  a_r5_invalid_flag: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !running && cfg_data[6] && cfg_data[5]) |=> cfg_err);

  // R10: a valid select pair clears the error flag
  a_r10_valid_clears: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !running && !(cfg_data[6] && cfg_data[5])) |=> !cfg_err);

  // R6: the coupling bit is taken on an accepted write
  a_r6_couple_flag: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !running) |=> (ac_coupled == $past(cfg_data[4])));

  // R5: in the invalid state the output tracks the internal oscillator
  a_r5_fallback_int: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !$past(rst) && !$past(rst, 2)) |=> (sync_clk_out == $past(int_osc, 3)));

endmodule

bind syncclk_divider syncclk_divider_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .int_osc      (int_osc),
  .cfg_wr       (cfg_wr),
  .cfg_data     (cfg_data),
  .running      (running),
  .sync_clk_out (sync_clk_out),
  .cfg_err      (cfg_err),
  .ac_coupled   (ac_coupled)
);

// File: tb/syncclk_divider_bench.sv
`timescale 1ns/1ps
module syncclk_divider_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_sync = 1'b0;
  logic       int_osc = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       running = 1'b0;
  logic       sync_clk_out;
  logic       cfg_err;
  logic       ac_coupled;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = !clk;

  syncclk_divider u_syncclk_divider (
    .clk          (clk),
    .rst          (rst),
    .ext_sync     (ext_sync),
    .int_osc      (int_osc),
    .cfg_wr       (cfg_wr),
    .cfg_data     (cfg_data),
    .running      (running),
    .sync_clk_out (sync_clk_out),
    .cfg_err      (cfg_err),
    .ac_coupled   (ac_coupled)
  );

  // Reference model: 0 internal, 3 / 6 divide ratio, -1 invalid pair.
  int ratio_m = 0;
  int cnt_m = 0;
  bit q_m = 0;
  bit out_m = 0;
  bit err_m = 0;
  bit ac_m = 0;
  bit ext_h[$];
  bit int_h[$];

  initial begin
    for (int k = 0; k < 4; k++) begin
      ext_h.push_back(1'b0);
      int_h.push_back(1'b0);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      ratio_m = 0; cnt_m = 0; q_m = 0; out_m = 0; err_m = 0; ac_m = 0;
      for (int k = 0; k < 4; k++) begin
        ext_h[k] = 1'b0;
        int_h[k] = 1'b0;
      end
    end else begin
      // ext_h[j] holds the level applied before edge n-1-j.
      out_m = (ratio_m > 0) ? q_m : int_h[1];
      if (cfg_wr && !running) begin
        cnt_m = 0;
        q_m = 0;
        ac_m = cfg_data[4];
        err_m = cfg_data[6] && cfg_data[5];
        if (err_m) ratio_m = -1;
        else if (cfg_data[6]) ratio_m = 3;
        else if (cfg_data[5]) ratio_m = 6;
        else ratio_m = 0;
      end else if (ratio_m > 0 && (ext_h[1] != ext_h[2])) begin
        cnt_m++;
        if (cnt_m == ratio_m) begin
          cnt_m = 0;
          q_m = !q_m;
        end
      end
      void'(ext_h.pop_back());
      ext_h.push_front(ext_sync);
      void'(int_h.pop_back());
      int_h.push_front(int_osc);
    end
  end

  task automatic check1(string req, string what, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // Compare every cycle on the falling edge, then drive new inputs.
  task automatic step(bit e, bit i);
    @(negedge clk);
    check1(cur_req, "sync_clk_out", sync_clk_out, out_m);
    check1(err_m ? "R5" : "R10", "cfg_err", cfg_err, err_m);
    check1("R6", "ac_coupled", ac_coupled, ac_m);
    ext_sync = e;
    int_osc = i;
    cfg_wr = 1'b0;
  endtask

  task automatic write_cfg(logic [7:0] v, bit run);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_data = v;
    running = run;
    @(negedge clk);
    cfg_wr = 1'b0;
    running = 1'b0;
  endtask

  int edges_seen;
  bit last_out;

  task automatic run_phase(int cycles, int ext_hold, int int_hold);
    for (int c = 0; c < cycles; c++) begin
      step((ext_hold > 0) ? ((c / ext_hold) % 2 == 1) : ext_sync,
           ((c / int_hold) % 2 == 1));
      if (sync_clk_out != last_out) edges_seen++;
      last_out = sync_clk_out;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1", "sync_clk_out reset", sync_clk_out, 1'b0);
    check1("R1", "cfg_err reset", cfg_err, 1'b0);
    check1("R1", "ac_coupled reset", ac_coupled, 1'b0);
    rst = 1'b0;

    // R2: internal oscillator passes through, ext ignored
    cur_req = "R2";
    run_phase(60, 2, 3);

    // R3: divide by 3, ext toggles every 2 cycles
    cur_req = "R3";
    write_cfg(8'h40, 1'b0);
    edges_seen = 0; last_out = sync_clk_out;
    run_phase(240, 2, 5);
    // 240 cycles -> 120 ext transitions -> about 40 output toggles
    checks++;
    if (edges_seen < 36 || edges_seen > 41) begin
      errors++;
      $display("FAIL R3 toggle count got %0d expected 36..41", edges_seen);
    end

    // R7: locked write of a different setting is discarded
    cur_req = "R7";
    write_cfg(8'h70, 1'b1);
    check1("R7", "cfg_err after locked write", cfg_err, 1'b0);
    check1("R7", "ac_coupled after locked write", ac_coupled, 1'b0);
    run_phase(40, 2, 5);

    // R4: divide by 6, ext toggles every 3 cycles
    cur_req = "R4";
    write_cfg(8'h20, 1'b0);
    edges_seen = 0; last_out = sync_clk_out;
    run_phase(360, 3, 4);
    checks++;
    if (edges_seen < 18 || edges_seen > 21) begin
      errors++;
      $display("FAIL R4 toggle count got %0d expected 18..21", edges_seen);
    end

    // R8: restart mid-count, ext toggles every cycle
    cur_req = "R8";
    run_phase(7, 1, 4);
    write_cfg(8'h40, 1'b0);
    @(negedge clk);
    check1("R8", "phase low after restart", sync_clk_out, 1'b0);
    run_phase(60, 1, 4);

    // R5: invalid pair, falls back to internal oscillator
    cur_req = "R5";
    write_cfg(8'h60, 1'b0);
    check1("R5", "cfg_err set", cfg_err, 1'b1);
    run_phase(60, 2, 3);

    // R10: valid pair clears the flag; R6 coupling bit
    cur_req = "R10";
    write_cfg(8'h50, 1'b0);
    check1("R10", "cfg_err cleared", cfg_err, 1'b0);
    check1("R6", "ac_coupled set", ac_coupled, 1'b1);
    run_phase(60, 3, 2);

    // R9: unused bits have no effect, selects stay idle
    cur_req = "R9";
    write_cfg(8'h8F, 1'b0);
    check1("R9", "cfg_err with spare bits", cfg_err, 1'b0);
    check1("R9", "ac_coupled with spare bits", ac_coupled, 1'b0);
    run_phase(60, 1, 3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule